// File: doc/BRIEF.md
# Complementary Dead-Time Gate Controller

This block turns one PWM command into two drive signals for a pair of complementary switches: a main power switch and an auxiliary switch (synchronous rectifier or active clamp). The two switches are never on together. Each one is turned on only after its own programmable dead time. The auxiliary switch is turned off at once when the command rises, and the main switch is turned on only after the on-delay. The main switch is turned off at once when the command falls, and the auxiliary switch is turned on only after the aux-delay.

Each dead time can be ended early by a zero-voltage sense strobe, so a switch can close as soon as its voltage has collapsed. A low enable puts the block to sleep. In sleep the main drive is held low and the auxiliary driver is released to high impedance. A variant select inverts the auxiliary drive so that it can control a P-channel device.

The PWM command and both sense strobes are asynchronous. Each passes through a two-flop synchronizer, and the block reacts to the synchronized levels. The enable input is sampled as a synchronous input.

Top module: `cdt_gate_ctrl`

## Requirements
- R1: When `pwm_i` rises, the auxiliary switch goes inactive 3 clocks after the change, counting two synchronizer stages and one state register. The main switch goes active exactly D1 clocks after that, where D1 is the clamped value of `dly_on_i`.
- R2: When `pwm_i` falls, `main_o` goes low 3 clocks after the change. The auxiliary switch goes active exactly D2 clocks after that, where D2 is the clamped value of `dly_aux_i`.
- R3: The two delays are independent. A programmed value below 5 acts as 5, and a value above 50 acts as 50.
- R4: While the on-delay is running, a high level on `zvs_on_i` makes `main_o` rise 3 clocks after the strobe changes, whatever count remains.
- R5: While the aux-delay is running, a high level on `zvs_aux_i` activates the auxiliary switch 3 clocks after the strobe changes.
- R6: If `pwm_i` falls before the on-delay has expired, `main_o` never rises. The aux-delay then runs in full from the falling edge.
- R7: If `pwm_i` rises before the aux-delay has expired, the auxiliary switch never activates. The on-delay then restarts in full.
- R8: When `en_i` is low at a clock edge, then after that edge `main_o` is 0, `aux_oe_o` is 0, and `aux_o` sits at its inactive level.
- R9: After `en_i` returns high, `aux_oe_o` is 1 from the next edge on. The outputs then restart as though an edge of the current PWM level had just been seen. With PWM high, `main_o` rises D1+1 clocks after the enable change. With PWM low, the auxiliary switch activates D2+1 clocks after it.
- R10: The auxiliary switch counts as active when `aux_oe_o` is 1 and `aux_o` differs from `aux_inv_i`. With `aux_inv_i`=0 an active switch is driven as `aux_o`=1. With `aux_inv_i`=1 it is driven as `aux_o`=0.
- R11: `main_o` and the active auxiliary switch are never both asserted in the same cycle.
- R12: If a PWM level change and the matching sense strobe reach the sequencer in the same cycle, the PWM change wins and the sense strobe has no effect.
- R13: While `rst_ni` is low, `main_o` and `aux_oe_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwm_i | input | 1 | PWM command, asynchronous |
| en_i | input | 1 | Enable, low selects sleep |
| dly_on_i | input | CNT_W | Dead time before main turn-on, in clocks |
| dly_aux_i | input | CNT_W | Dead time before auxiliary activation, in clocks |
| zvs_on_i | input | 1 | Sense strobe that ends the on-delay |
| zvs_aux_i | input | 1 | Sense strobe that ends the aux-delay |
| aux_inv_i | input | 1 | 1 selects the inverted auxiliary drive |
| main_o | output | 1 | Main switch drive |
| aux_o | output | 1 | Auxiliary switch drive |
| aux_oe_o | output | 1 | Auxiliary driver enable, 0 means high impedance |

## Verification
Two functions can collide in one cycle: the sense strobe for a running dead time, and a reversal of the PWM command that cancels that same dead time. The bench provokes the collision by changing `pwm_i` and `zvs_on_i` on the same clock while the on-delay is running, so that both pass the synchronizer together. The result is judged at the ports. `main_o` must stay low for the whole window, and the auxiliary switch must activate only after the full aux-delay measured from the falling edge.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  typedef enum logic [2:0] {
    ST_SLEEP,
    ST_ON_WAIT,
    ST_ON,
    ST_AUX_WAIT,
    ST_AUX
  } cdt_state_e;

  localparam int unsigned TMR_ON  = 0;
  localparam int unsigned TMR_AUX = 1;
  localparam int unsigned N_TMR   = 2;
endpackage

// File: rtl/cdt_sync.sv
module cdt_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
    end else begin
      pipe_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/cdt_dead_timer.sv
module cdt_dead_timer #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned DLY_MIN = 5,
  parameter int unsigned DLY_MAX = 50
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] dly_i,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] MIN_C = CNT_W'(DLY_MIN);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(DLY_MAX);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  logic [CNT_W-1:0] ld_val;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    if (dly_i < MIN_C)      ld_val = MIN_C;
    else if (dly_i > MAX_C) ld_val = MAX_C;
    else                    ld_val = dly_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= MIN_C;
    else if (load_i)                cnt_q <= ld_val;
    else if (run_i && cnt_q > ONE_C) cnt_q <= cnt_q - ONE_C;
  end

  // last cycle of the window: the transition happens at this edge
  assign expire_o = run_i && (cnt_q == ONE_C);
endmodule

// File: rtl/cdt_seq.sv
module cdt_seq
  import cdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             pwm_s_i,
  input  logic [N_TMR-1:0] zvs_s_i,
  input  logic [N_TMR-1:0] expire_i,
  output logic [N_TMR-1:0] load_o,
  output logic [N_TMR-1:0] run_o,
  output logic             main_o,
  output logic             aux_act_o,
  output logic             aux_oe_o
);
  cdt_state_e state_q, state_d;
  logic main_q, aux_q, oe_q;

  always_comb begin
    state_d = state_q;
    if (!en_i) begin
      state_d = ST_SLEEP;
    end else begin
      unique case (state_q)
        ST_SLEEP:    state_d = pwm_s_i ? ST_ON_WAIT : ST_AUX_WAIT;
        // pwm reversal outranks sense strobe and timer expiry
        ST_ON_WAIT: begin
          if (!pwm_s_i)                                  state_d = ST_AUX_WAIT;
          else if (expire_i[TMR_ON] || zvs_s_i[TMR_ON])  state_d = ST_ON;
        end
        ST_ON:       if (!pwm_s_i) state_d = ST_AUX_WAIT;
        ST_AUX_WAIT: begin
          if (pwm_s_i)                                   state_d = ST_ON_WAIT;
          else if (expire_i[TMR_AUX] || zvs_s_i[TMR_AUX]) state_d = ST_AUX;
        end
        ST_AUX:      if (pwm_s_i) state_d = ST_ON_WAIT;
        default:     state_d = ST_SLEEP;
      endcase
    end
  end

  assign load_o[TMR_ON]  = (state_d == ST_ON_WAIT)  && (state_q != ST_ON_WAIT);
  assign load_o[TMR_AUX] = (state_d == ST_AUX_WAIT) && (state_q != ST_AUX_WAIT);
  assign run_o[TMR_ON]   = (state_q == ST_ON_WAIT);
  assign run_o[TMR_AUX]  = (state_q == ST_AUX_WAIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SLEEP;
      main_q  <= 1'b0;
      aux_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      main_q  <= (state_d == ST_ON);
      aux_q   <= (state_d == ST_AUX);
      oe_q    <= (state_d != ST_SLEEP);
    end
  end

  assign main_o    = main_q;
  assign aux_act_o = aux_q;
  assign aux_oe_o  = oe_q;
endmodule

// File: rtl/cdt_gate_ctrl.sv
module cdt_gate_ctrl
  import cdt_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned DLY_MIN     = 5,
  parameter int unsigned DLY_MAX     = 50,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwm_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] dly_on_i,
  input  logic [CNT_W-1:0] dly_aux_i,
  input  logic             zvs_on_i,
  input  logic             zvs_aux_i,
  input  logic             aux_inv_i,
  output logic             main_o,
  output logic             aux_o,
  output logic             aux_oe_o
);
  localparam int unsigned SYNC_W = N_TMR + 1;

  logic [SYNC_W-1:0]            sync_s;
  logic                         pwm_s;
  logic [N_TMR-1:0]             zvs_s;
  logic [N_TMR-1:0]             load, run, expire;
  logic [N_TMR-1:0][CNT_W-1:0]  dly_arr;
  logic                         aux_act;

  cdt_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({zvs_aux_i, zvs_on_i, pwm_i}),
    .q_o   (sync_s)
  );

  assign pwm_s = sync_s[0];
  assign zvs_s = sync_s[SYNC_W-1:1];

  assign dly_arr[TMR_ON]  = dly_on_i;
  assign dly_arr[TMR_AUX] = dly_aux_i;

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    cdt_dead_timer #(.CNT_W(CNT_W), .DLY_MIN(DLY_MIN), .DLY_MAX(DLY_MAX)) u_tmr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (load[g]),
      .run_i   (run[g]),
      .dly_i   (dly_arr[g]),
      .expire_o(expire[g])
    );
  end

  cdt_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .pwm_s_i  (pwm_s),
    .zvs_s_i  (zvs_s),
    .expire_i (expire),
    .load_o   (load),
    .run_o    (run),
    .main_o   (main_o),
    .aux_act_o(aux_act),
    .aux_oe_o (aux_oe_o)
  );

  assign aux_o = aux_act ^ aux_inv_i;
endmodule

// File: rtl/cdt_gate_ctrl_chk.sv
module cdt_gate_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic aux_inv_i,
  input logic main_o,
  input logic aux_o,
  input logic aux_oe_o
);
  logic aux_on;
  assign aux_on = aux_oe_o && (aux_o != aux_inv_i);

  // R11
  overlap_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_o |-> !aux_on);

  // R8
  sleep_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!main_o && !aux_oe_o));

  // R9
  wake_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> aux_oe_o);

  // R1
  main_rise_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(main_o) |-> ($past(!aux_on) && $past(en_i)));

  // R2
  aux_rise_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(aux_on) |-> $past(!main_o));
endmodule

bind cdt_gate_ctrl cdt_gate_ctrl_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .aux_inv_i(aux_inv_i),
  .main_o   (main_o),
  .aux_o    (aux_o),
  .aux_oe_o (aux_oe_o)
);

// File: tb/cdt_gate_ctrl_bench.sv
`timescale 1ns/1ps
module cdt_gate_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_ni, pwm, en, zvs_on, zvs_aux, inv;
  logic [7:0] d_on, d_aux;
  logic       main_o, aux_o, aux_oe_o;

  int n_chk = 0, n_fail = 0, n_ovl = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cdt_gate_ctrl u_cdt_gate_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .pwm_i(pwm), .en_i(en),
    .dly_on_i(d_on), .dly_aux_i(d_aux), .zvs_on_i(zvs_on), .zvs_aux_i(zvs_aux),
    .aux_inv_i(inv), .main_o(main_o), .aux_o(aux_o), .aux_oe_o(aux_oe_o)
  );

  typedef struct packed {
    logic [7:0] t1;
    logic [7:0] t2;
    logic       iv;
    logic [7:0] e1;
    logic [7:0] e2;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'd10,  8'd20, 1'b0, 8'd10, 8'd20},
    '{8'd30,  8'd7,  1'b1, 8'd30, 8'd7 },
    '{8'd0,   8'd3,  1'b0, 8'd5,  8'd5 },
    '{8'd255, 8'd60, 1'b1, 8'd50, 8'd50},
    '{8'd5,   8'd50, 1'b0, 8'd5,  8'd50},
    '{8'd50,  8'd5,  1'b1, 8'd50, 8'd5 }
  };

  function automatic bit aux_act();
    return aux_oe_o && (aux_o != inv);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // first sample index (negedges after call) of each output event, -1 if none
  task automatic watch(input int n, output int a_on, output int a_off,
                       output int m_on, output int m_off);
    a_on = -1; a_off = -1; m_on = -1; m_off = -1;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (main_o && aux_act()) n_ovl++;
      if (a_on  < 0 &&  aux_act()) a_on  = i;
      if (a_off < 0 && !aux_act()) a_off = i;
      if (m_on  < 0 &&  main_o)    m_on  = i;
      if (m_off < 0 && !main_o)    m_off = i;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int ao, af, mo, mf;
    rst_ni = 1'b0; en = 1'b0; pwm = 1'b0; zvs_on = 1'b0; zvs_aux = 1'b0;
    inv = 1'b0; d_on = 8'd10; d_aux = 8'd20;
    repeat (3) @(negedge clk);
    chk(!main_o && !aux_oe_o, "R13 reset", {main_o, aux_oe_o}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk(!main_o && !aux_oe_o && aux_o == inv, "R8 sleep after reset",
        {main_o, aux_oe_o, aux_o}, 0);

    // wake with pwm low
    en = 1'b1;
    watch(40, ao, af, mo, mf);
    chk(ao == 21, "R9 wake low aux", ao, 21);
    chk(mo == -1, "R9 wake low main", mo, -1);

    // vector table: delays, clamp, polarity
    for (int v = 0; v < 6; v++) begin
      d_on = VECS[v].t1; d_aux = VECS[v].t2; inv = VECS[v].iv;
      repeat (2) @(negedge clk);
      chk(aux_o == ~inv, "R10 aux level", aux_o, ~inv);
      pwm = 1'b1;
      watch(100, ao, af, mo, mf);
      chk(af == 3, "R1 aux off", af, 3);
      chk(mo == 3 + int'(VECS[v].e1), "R1 R3 main on", mo, 3 + int'(VECS[v].e1));
      pwm = 1'b0;
      watch(100, ao, af, mo, mf);
      chk(mf == 3, "R2 main off", mf, 3);
      chk(ao == 3 + int'(VECS[v].e2), "R2 R3 aux on", ao, 3 + int'(VECS[v].e2));
    end

    inv = 1'b0; d_on = 8'd20; d_aux = 8'd20;
    repeat (2) @(negedge clk);

    // R6: pwm falls during on-delay
    pwm = 1'b1;
    watch(6, ao, af, mo, mf);
    pwm = 1'b0;
    watch(60, ao, af, mo, mf);
    chk(mo == -1, "R6 main stays off", mo, -1);
    chk(ao == 23, "R6 aux after full T2", ao, 23);

    // R7: pwm rises during aux-delay
    pwm = 1'b1;
    watch(60, ao, af, mo, mf);
    pwm = 1'b0;
    watch(6, ao, af, mo, mf);
    pwm = 1'b1;
    watch(60, ao, af, mo, mf);
    chk(ao == -1, "R7 aux stays off", ao, -1);
    chk(mo == 23, "R7 main after full T1", mo, 23);
    pwm = 1'b0;
    watch(60, ao, af, mo, mf);

    // R4: sense ends on-delay
    d_on = 8'd50; d_aux = 8'd50;
    pwm = 1'b1;
    watch(10, ao, af, mo, mf);
    zvs_on = 1'b1;
    watch(20, ao, af, mo, mf);
    chk(mo == 3, "R4 sense on", mo, 3);
    zvs_on = 1'b0;

    // R5: sense ends aux-delay
    pwm = 1'b0;
    watch(10, ao, af, mo, mf);
    zvs_aux = 1'b1;
    watch(20, ao, af, mo, mf);
    chk(ao == 3, "R5 sense aux", ao, 3);
    zvs_aux = 1'b0;
    repeat (4) @(negedge clk);

    // R12: pwm reversal and sense strobe arrive together
    pwm = 1'b1;
    watch(10, ao, af, mo, mf);
    pwm = 1'b0; zvs_on = 1'b1;
    watch(80, ao, af, mo, mf);
    chk(mo == -1, "R12 main stays off", mo, -1);
    chk(ao == 53, "R12 aux after full T2", ao, 53);
    zvs_on = 1'b0;
    repeat (4) @(negedge clk);

    // R8: sleep from main-on
    d_on = 8'd10; d_aux = 8'd10;
    pwm = 1'b1;
    watch(30, ao, af, mo, mf);
    en = 1'b0;
    @(negedge clk);
    chk(!main_o && !aux_oe_o && aux_o == inv, "R8 sleep forces outputs",
        {main_o, aux_oe_o, aux_o}, 0);
    repeat (5) @(negedge clk);

    // R9: wake with pwm high
    en = 1'b1;
    watch(30, ao, af, mo, mf);
    chk(mo == 11, "R9 wake high main", mo, 11);
    chk(aux_oe_o && ao == -1, "R9 wake high aux", ao, -1);

    chk(n_ovl == 0, "R11 no overlap", n_ovl, 0);
    finish_run();
  end
endmodule